// File: doc/BRIEF.md
# Serial Synthesiser Programming Loader

This block receives divider settings for a dual-modulus frequency synthesiser over a three-wire serial link (a serial clock, a data line and a frame enable). It drives three holding latches: a 7-bit swallow count, a 10-bit main count and an 11-bit reference count. These latches feed the divider chain. The serial lines are asynchronous to the block's system clock, so they are synchronised and their edges are detected in the system clock domain.

A frame opens when the enable line goes high. Each rising edge of the serial clock while enable is high shifts in one data bit, and the bits are counted. When enable falls, the length of the frame selects what happens. A 28-bit frame reloads all three latches. A 17-bit frame reloads only the swallow and main counts, which allows a quick channel change. Any other length is thrown away. The latches change only at the close of a frame and never while bits are still arriving.

Top module: `synth_prog_loader`

## Requirements
- R1: While `rst_n` is low, and after it is released, `swallowCnt`, `mainCnt` and `refCnt` all read zero until a valid frame closes.
- R2: A frame of exactly 28 bits loads all three outputs when enable falls. Bits are sent MSB first: the first 7 bits form `swallowCnt` (bit 6 first), the next 10 bits form `mainCnt` (bit 9 first), and the last 11 bits form `refCnt` (bit 10 first, bit 0 last).
- R3: A frame of exactly 17 bits loads `swallowCnt` from its first 7 bits and `mainCnt` from its last 10 bits, both MSB first, when enable falls. `refCnt` keeps its previous value.
- R4: A frame of any length other than 17 or 28, including zero bits, leaves all three outputs unchanged.
- R5: The bit count saturates and does not wrap. A frame of 49 or 60 bits is rejected (R4 behaviour) and is not treated as 17 or 28.
- R6: Serial clock edges and data changes while enable is low are ignored. They change no output, and they are not counted in the next frame.
- R7: Outputs change only after enable falls. A frame that already holds 28 bits but still has enable high leaves the outputs at their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial bit clock; data is taken on its rising edge |
| serData | input | 1 | Serial data, MSB of the swallow field first |
| serEn | input | 1 | Frame enable; high while a frame is being sent |
| swallowCnt | output | 7 | Latched swallow count |
| mainCnt | output | 10 | Latched main count |
| refCnt | output | 11 | Latched reference count |

## Verification
The bench sweeps the frame length from 0 to 40 bits, then tries 45, 49 and 60. Only lengths 17 and 28 may change anything. A design that compares against the wrong count, or whose counter wraps, would load on lengths 16, 18, 27, 29, 49 or 60. Full and short frames carry many distinct field values, and each short frame is checked to leave the reference count alone. A slicing error would scramble fields, and a short load that also wrote the reference latch would show up as a changed `refCnt`. Two further tests target a design that takes clock edges outside a frame or loads early. The first sends stray clock edges while enable is low. The second holds a complete 28-bit frame open before closing it. Such a design would shift in stray bits or update the outputs before enable falls.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

  // Strobes passed from the control path to the datapath each system clock.
  typedef struct packed {
    logic shift;   // take one serial bit into the shift register
    logic bitIn;   // the synchronised data bit to take
    logic loadAm;  // transfer swallow and main fields to the latches
    logic loadR;   // also transfer the reference field (full frame)
  } progStrobe_t;

endpackage

// File: rtl/synth_prog_ctrl.sv
module synth_prog_ctrl
  import synth_prog_pkg::*;
#(
  parameter int FULL_LEN    = 28,
  parameter int SHORT_LEN   = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        serClk,
  input  logic        serData,
  input  logic        serEn,
  output progStrobe_t strobe
);

  localparam int CNT_W = $clog2(FULL_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] FULL_C  = CNT_W'(FULL_LEN);
  localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_LEN);

  logic [SYNC_STAGES-1:0] clkSync, datSync, enSync;
  logic                   clkPrev, enPrev;
  logic [CNT_W-1:0]       bitCnt;
  logic                   clkNow, enNow, datNow;
  logic                   clkRise, enFall, shiftNow;

  // Bring the three serial lines into the system clock domain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkSync <= '0;
      datSync <= '0;
      enSync  <= '0;
      clkPrev <= 1'b0;
      enPrev  <= 1'b0;
    end else begin
      clkSync <= {clkSync[SYNC_STAGES-2:0], serClk};
      datSync <= {datSync[SYNC_STAGES-2:0], serData};
      enSync  <= {enSync[SYNC_STAGES-2:0], serEn};
      clkPrev <= clkSync[SYNC_STAGES-1];
      enPrev  <= enSync[SYNC_STAGES-1];
    end
  end

  always_comb begin
    clkNow   = clkSync[SYNC_STAGES-1];
    enNow    = enSync[SYNC_STAGES-1];
    datNow   = datSync[SYNC_STAGES-1];
    clkRise  = clkNow & ~clkPrev;
    enFall   = enPrev & ~enNow;
    shiftNow = clkRise & enNow;
  end

  // Saturating bit counter; cleared while the frame is closed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt <= '0;
    end else if (!enNow) begin
      bitCnt <= '0;
    end else if (shiftNow && (bitCnt != CNT_MAX)) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.shift  = shiftNow;
    strobe.bitIn  = datNow;
    strobe.loadR  = enFall && (bitCnt == FULL_C);
    strobe.loadAm = enFall && ((bitCnt == FULL_C) || (bitCnt == SHORT_C));
  end

  // R5
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bitCnt == CNT_MAX) |=> ((bitCnt == CNT_MAX) || (bitCnt == '0)));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((bitCnt == $past(bitCnt)) || (bitCnt == $past(bitCnt) + 1'b1)
              || (bitCnt == '0)));

endmodule

// File: rtl/synth_prog_dp.sv
module synth_prog_dp
  import synth_prog_pkg::*;
#(
  parameter int A_W = 7,
  parameter int M_W = 10,
  parameter int R_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  progStrobe_t    strobe,
  output logic [A_W-1:0] aQ,
  output logic [M_W-1:0] mQ,
  output logic [R_W-1:0] rQ
);

  localparam int FULL_LEN = A_W + M_W + R_W;

  logic [FULL_LEN-1:0] shiftReg;

  // New bits enter at the bottom, so the first bit sent ends up highest.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
    end else if (strobe.shift) begin
      shiftReg <= {shiftReg[FULL_LEN-2:0], strobe.bitIn};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aQ <= '0;
      mQ <= '0;
      rQ <= '0;
    end else if (strobe.loadR) begin
      aQ <= shiftReg[FULL_LEN-1 -: A_W];
      mQ <= shiftReg[R_W +: M_W];
      rQ <= shiftReg[R_W-1:0];
    end else if (strobe.loadAm) begin
      aQ <= shiftReg[M_W +: A_W];
      mQ <= shiftReg[M_W-1:0];
    end
  end

  // R2
  load_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadR |-> strobe.loadAm);

  // R3
  r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.loadR |=> $stable(rQ));

  // R4
  am_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.loadAm |=> ($stable(aQ) && $stable(mQ)));

  // R7
  shift_load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.shift |-> !strobe.loadAm);

endmodule

// File: rtl/synth_prog_loader.sv
module synth_prog_loader
  import synth_prog_pkg::*;
#(
  parameter int A_W         = 7,
  parameter int M_W         = 10,
  parameter int R_W         = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           serClk,
  input  logic           serData,
  input  logic           serEn,
  output logic [A_W-1:0] swallowCnt,
  output logic [M_W-1:0] mainCnt,
  output logic [R_W-1:0] refCnt
);

  localparam int FULL_LEN  = A_W + M_W + R_W;
  localparam int SHORT_LEN = A_W + M_W;

  progStrobe_t strobe;

  synth_prog_ctrl #(
    .FULL_LEN   (FULL_LEN),
    .SHORT_LEN  (SHORT_LEN),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .serClk (serClk),
    .serData(serData),
    .serEn  (serEn),
    .strobe (strobe)
  );

  synth_prog_dp #(
    .A_W(A_W),
    .M_W(M_W),
    .R_W(R_W)
  ) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(strobe),
    .aQ    (swallowCnt),
    .mQ    (mainCnt),
    .rQ    (refCnt)
  );

endmodule

// File: tb/sim_synth_prog_loader.sv
module sim_synth_prog_loader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        serClk = 1'b0;
  logic        serData = 1'b0;
  logic        serEn = 1'b0;
  logic [6:0]  swallowCnt;
  logic [9:0]  mainCnt;
  logic [10:0] refCnt;

  logic [6:0]  expA = '0;
  logic [9:0]  expM = '0;
  logic [10:0] expR = '0;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  synth_prog_loader u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .serClk    (serClk),
    .serData   (serData),
    .serEn     (serEn),
    .swallowCnt(swallowCnt),
    .mainCnt   (mainCnt),
    .refCnt    (refCnt)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkOut(input string req);
    checks++;
    if ((swallowCnt !== expA) || (mainCnt !== expM) || (refCnt !== expR)) begin
      errors++;
      $display("FAIL %s: got A=%h M=%h R=%h expected A=%h M=%h R=%h",
               req, swallowCnt, mainCnt, refCnt, expA, expM, expR);
    end
  endtask

  task automatic openFrame();
    serEn = 1'b1;
    waitCyc(4);
  endtask

  task automatic sendBits(input logic [63:0] bits, input int len);
    for (int i = len - 1; i >= 0; i--) begin
      serData = bits[i];
      waitCyc(4);
      serClk = 1'b1;
      waitCyc(4);
      serClk = 1'b0;
    end
  endtask

  task automatic closeFrame();
    waitCyc(4);
    serEn = 1'b0;
    waitCyc(8);
  endtask

  // Expected-value model built from R2, R3 and R4.
  task automatic model(input logic [63:0] bits, input int len);
    if (len == 28) begin
      expA = bits[27:21];
      expM = bits[20:11];
      expR = bits[10:0];
    end else if (len == 17) begin
      expA = bits[16:10];
      expM = bits[9:0];
    end
  endtask

  task automatic frame(input logic [63:0] bits, input int len);
    openFrame();
    sendBits(bits, len);
    closeFrame();
    model(bits, len);
  endtask

  initial begin
    waitCyc(3);
    // R1: outputs are zero while reset is held
    checkOut("R1 during reset");
    rst_n = 1'b1;
    waitCyc(3);
    checkOut("R1 after reset");

    // R2: full frames with many field values
    for (int i = 0; i < 16; i++) begin
      logic [6:0]  a = 7'((i * 37 + 5) & 127);
      logic [9:0]  m = 10'((i * 291 + 17) & 1023);
      logic [10:0] r = 11'((i * 733 + 1029) & 2047);
      frame({36'd0, a, m, r}, 28);
      checkOut("R2 full frame");
    end

    // R3: short frames; refCnt must keep its value
    for (int i = 0; i < 16; i++) begin
      logic [6:0] a = 7'((i * 53 + 100) & 127);
      logic [9:0] m = 10'((i * 419 + 3) & 1023);
      frame({47'd0, a, m}, 17);
      checkOut("R3 short frame");
    end

    // R4 (with R2/R3 at 28 and 17): every length from 0 to 40
    for (int len = 0; len <= 40; len++) begin
      logic [63:0] bits = 64'hA5C3_96F0_1E2D_3B4C ^ (64'(len) * 64'h0101_0101_0101_0101);
      frame(bits, len);
      if (len == 28) checkOut("R2 length sweep");
      else if (len == 17) checkOut("R3 length sweep");
      else checkOut("R4 length sweep");
    end

    // R5: over-long frames that would alias to 17 or 28 in a 5-bit wrapping counter
    frame(64'h0F0F_1234_5678_9ABC, 49);
    checkOut("R5 length 49");
    frame(64'hFEDC_BA98_7654_3210, 60);
    checkOut("R5 length 60");
    frame(64'h1357_9BDF_2468_ACE0, 45);
    checkOut("R5 length 45");

    // R6: clock edges and data while enable is low
    for (int i = 0; i < 20; i++) begin
      serData = i[0] ^ i[2];
      waitCyc(4);
      serClk = 1'b1;
      waitCyc(4);
      serClk = 1'b0;
    end
    waitCyc(8);
    checkOut("R6 idle clocks ignored");
    frame({47'd0, 7'h5A, 10'h2C3}, 17);
    checkOut("R6 frame after idle clocks");

    // R7: complete 28-bit frame held open must not load yet
    begin
      logic [63:0] bits = {36'd0, 7'h33, 10'h155, 11'h6AB};
      openFrame();
      sendBits(bits, 28);
      waitCyc(12);
      checkOut("R7 frame still open");
      closeFrame();
      model(bits, 28);
      checkOut("R7 after close");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule